// File: doc/BRIEF.md
# Bus-Connected Status Flag with Activity LED Output

This block holds a single hardware flag that records whether the controller is currently attached to the parallel peripheral bus. The attachment can be as initiator or as target. The flag is set by one-cycle event pulses from the bus protocol engine and cleared by a bus-free or disconnect pulse. Software sees the flag at bit 3 of the status read port and cannot change it.

The same flag can drive an activity LED on general-purpose pin 0. The pin follows the flag only when three conditions all hold: LED mode is requested in the pin control value, instruction fetch on that pin is not enabled, and no EEPROM autodownload is running. If any of the three is missing, pin 0 behaves as an ordinary GPIO and takes its value and direction from the data and direction registers. The remaining pins always behave as ordinary GPIO. Pad outputs are registered.

Top module: `busconn_led`

## Requirements
- R1: After reset, `conn` is 0, `stat_q` is all zeros, and every bit of `pad_out` and `pad_oe` is 0.
- R2: A pulse on `ev_sel_done` (selection completed as initiator) makes `conn` 1 at the following clock edge.
- R3: A pulse on `ev_tgt_resp` (successful response to selection or reselection as target) makes `conn` 1 at the following clock edge.
- R4: A pulse on `ev_arb_won` (arbitration won in low-level mode) makes `conn` 1 at the following clock edge.
- R5: A pulse on `ev_drop` (bus free or disconnect) makes `conn` 0 at the following clock edge. It takes priority over any set pulse in the same cycle. When there is no pulse, `conn` holds its value.
- R6: `stat_q` carries `conn` at bit 3 and zeros in all other bits. A write through `stat_wr_en` and `stat_wr_data`, with any data, leaves `conn` and `stat_q` unchanged.
- R7: LED mode is qualified when `gpctl[5]` is 1, `gpctl[6]` is 0 and `autodl_busy` is 0. In LED mode, `pad_out[0]` equals `conn` (with the default active-high polarity) and `pad_oe[0]` is 1.
- R8: When LED mode is not qualified, `pad_out[0]` equals `gpio_dout[0]` and `pad_oe[0]` equals `gpio_dir[0]`.
- R9: For every pin above 0, `pad_out` follows `gpio_dout` and `pad_oe` follows `gpio_dir`, whatever the state of LED mode.
- R10: The pads are registered. A change of `conn`, of the qualification inputs or of the GPIO registers reaches `pad_out` and `pad_oe` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_sel_done | input | 1 | Initiator selection completed pulse |
| ev_tgt_resp | input | 1 | Target responded to selection/reselection pulse |
| ev_arb_won | input | 1 | Low-level arbitration won pulse |
| ev_drop | input | 1 | Bus free / disconnect pulse |
| gpctl | input | CTRL_W | Pin control register value (bit 5 LED request, bit 6 fetch enable) |
| autodl_busy | input | 1 | EEPROM autodownload in progress |
| gpio_dout | input | GPIO_W | GPIO data register |
| gpio_dir | input | GPIO_W | GPIO direction register, 1 = output |
| stat_wr_en | input | 1 | Software write strobe to the status register |
| stat_wr_data | input | STAT_W | Software write data (ignored) |
| conn | output | 1 | Connected flag |
| stat_q | output | STAT_W | Status register read value |
| pad_out | output | GPIO_W | Pad output values |
| pad_oe | output | GPIO_W | Pad output enables |

## Verification
The assertions assume that the event inputs are clean single-cycle pulses, synchronous to `clk`, and that reset is applied before the first check. They also assume that the control and GPIO inputs change only between clock edges. The bench drives every input on the falling edge and releases each event after exactly one cycle. It also samples outputs on the falling edge. Because of this, each registered stage can be counted cycle by cycle, and every combination of the three qualifying conditions, the flag state and the pin-0 data and direction bits is reached.

// File: rtl/busconn_pkg.sv
package busconn_pkg;
   typedef struct packed {
      logic sel_done;
      logic tgt_resp;
      logic arb_won;
      logic drop;
   } conn_ev_t;

   function automatic logic any_set(conn_ev_t e);
      return e.sel_done | e.tgt_resp | e.arb_won;
   endfunction
endpackage

// File: rtl/conn_flag_tracker.sv
module conn_flag_tracker
   import busconn_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  conn_ev_t ev,
   output logic     conn_o
);
   logic set_req;
   logic conn_q;

   assign set_req = any_set(ev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          conn_q <= 1'b0;
      else if (ev.drop)    conn_q <= 1'b0;
      else if (set_req)    conn_q <= 1'b1;
   end

   assign conn_o = conn_q;

   // R2 R3 R4: any set event without a drop raises the flag
   assert_set_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_req && !ev.drop) |=> conn_o);
   // R5: drop clears, even against a simultaneous set
   assert_drop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ev.drop |=> !conn_o);
   // R5: quiet cycles hold the flag
   assert_hold_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_req && !ev.drop) |=> $stable(conn_o));
endmodule

// File: rtl/led_qualifier.sv
module led_qualifier #(
   parameter int CTRL_W    = 8,
   parameter int LED_BIT   = 5,
   parameter int FETCH_BIT = 6
) (
   input  logic [CTRL_W-1:0] gpctl,
   input  logic              autodl_busy,
   output logic              led_mode_o
);
   initial begin
      assert (LED_BIT < CTRL_W && FETCH_BIT < CTRL_W && LED_BIT != FETCH_BIT)
         else $fatal(1, "led_qualifier: control bit positions out of range");
   end

   always_comb begin
      led_mode_o = gpctl[LED_BIT] & ~gpctl[FETCH_BIT] & ~autodl_busy;
   end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
   parameter int GPIO_W         = 5,
   parameter bit LED_ACTIVE_LOW = 1'b0,
   parameter bit PAD_REG        = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              led_mode,
   input  logic              conn,
   input  logic [GPIO_W-1:0] gpio_dout,
   input  logic [GPIO_W-1:0] gpio_dir,
   output logic [GPIO_W-1:0] pad_out,
   output logic [GPIO_W-1:0] pad_oe
);
   localparam int UPPER = GPIO_W - 1;

   initial begin
      assert (GPIO_W >= 1) else $fatal(1, "gpio_pad_mux: GPIO_W must be at least 1");
   end

   logic              led_level;
   logic [GPIO_W-1:0] nxt_out;
   logic [GPIO_W-1:0] nxt_oe;

   generate
      if (LED_ACTIVE_LOW) begin : g_led_lo
         assign led_level = ~conn;
      end else begin : g_led_hi
         assign led_level = conn;
      end
   endgenerate

   always_comb begin
      nxt_out = gpio_dout;
      nxt_oe  = gpio_dir;
      if (led_mode) begin
         nxt_out[0] = led_level;
         nxt_oe[0]  = 1'b1;
      end
   end

   generate
      if (PAD_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pad_out <= '0;
               pad_oe  <= '0;
            end else begin
               pad_out <= nxt_out;
               pad_oe  <= nxt_oe;
            end
         end

         // R7: qualified LED mode shows the flag one edge later
         assert_led_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
            led_mode |=> (pad_oe[0] && (pad_out[0] == (LED_ACTIVE_LOW ? ~$past(conn) : $past(conn)))));
         // R8: unqualified pin 0 is plain GPIO
         assert_gpio_fallback_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !led_mode |=> (pad_out[0] == $past(gpio_dout[0]) && pad_oe[0] == $past(gpio_dir[0])));
         if (UPPER > 0) begin : g_upper_chk
            // R9: upper pins ignore LED mode
            assert_upper_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
               1'b1 |=> (pad_out[GPIO_W-1:1] == $past(gpio_dout[GPIO_W-1:1])
                         && pad_oe[GPIO_W-1:1] == $past(gpio_dir[GPIO_W-1:1])));
         end
      end else begin : g_comb
         assign pad_out = nxt_out;
         assign pad_oe  = nxt_oe;
      end
   endgenerate
endmodule

// File: rtl/busconn_led.sv
module busconn_led
   import busconn_pkg::*;
#(
   parameter int CTRL_W         = 8,
   parameter int LED_BIT        = 5,
   parameter int FETCH_BIT      = 6,
   parameter int STAT_W         = 8,
   parameter int CONN_BIT       = 3,
   parameter int GPIO_W         = 5,
   parameter bit LED_ACTIVE_LOW = 1'b0,
   parameter bit PAD_REG        = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_sel_done,
   input  logic              ev_tgt_resp,
   input  logic              ev_arb_won,
   input  logic              ev_drop,
   input  logic [CTRL_W-1:0] gpctl,
   input  logic              autodl_busy,
   input  logic [GPIO_W-1:0] gpio_dout,
   input  logic [GPIO_W-1:0] gpio_dir,
   input  logic              stat_wr_en,
   input  logic [STAT_W-1:0] stat_wr_data,
   output logic              conn,
   output logic [STAT_W-1:0] stat_q,
   output logic [GPIO_W-1:0] pad_out,
   output logic [GPIO_W-1:0] pad_oe
);
   initial begin
      assert (CONN_BIT < STAT_W) else $fatal(1, "busconn_led: CONN_BIT outside status width");
   end

   conn_ev_t ev;
   logic     led_mode;

   assign ev = '{sel_done: ev_sel_done, tgt_resp: ev_tgt_resp,
                 arb_won:  ev_arb_won,  drop:     ev_drop};

   conn_flag_tracker u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (ev),
      .conn_o (conn)
   );

   led_qualifier #(
      .CTRL_W    (CTRL_W),
      .LED_BIT   (LED_BIT),
      .FETCH_BIT (FETCH_BIT)
   ) u_qual (
      .gpctl       (gpctl),
      .autodl_busy (autodl_busy),
      .led_mode_o  (led_mode)
   );

   gpio_pad_mux #(
      .GPIO_W         (GPIO_W),
      .LED_ACTIVE_LOW (LED_ACTIVE_LOW),
      .PAD_REG        (PAD_REG)
   ) u_pad (
      .clk       (clk),
      .rst_n     (rst_n),
      .led_mode  (led_mode),
      .conn      (conn),
      .gpio_dout (gpio_dout),
      .gpio_dir  (gpio_dir),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe)
   );

   always_comb begin
      stat_q           = '0;
      stat_q[CONN_BIT] = conn;
   end

   // R6: a software write with no bus event leaves the flag alone
   assert_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr_en && (stat_wr_data != '0 || stat_wr_data == '0) && !ev_drop
       && !ev_sel_done && !ev_tgt_resp && !ev_arb_won) |=> $stable(stat_q));
endmodule

// File: tb/tb_busconn_led.sv
`timescale 1ns/1ps
module tb_busconn_led;
   localparam int GW = 5;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ev_sel_done, ev_tgt_resp, ev_arb_won, ev_drop;
   logic [7:0]    gpctl;
   logic          autodl_busy;
   logic [GW-1:0] gpio_dout, gpio_dir;
   logic          stat_wr_en;
   logic [7:0]    stat_wr_data;
   logic          conn;
   logic [7:0]    stat_q;
   logic [GW-1:0] pad_out, pad_oe;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   busconn_led dut (
      .clk(clk), .rst_n(rst_n),
      .ev_sel_done(ev_sel_done), .ev_tgt_resp(ev_tgt_resp),
      .ev_arb_won(ev_arb_won), .ev_drop(ev_drop),
      .gpctl(gpctl), .autodl_busy(autodl_busy),
      .gpio_dout(gpio_dout), .gpio_dir(gpio_dir),
      .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
      .conn(conn), .stat_q(stat_q), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic pulse(int which);
      ev_sel_done = (which == 0);
      ev_tgt_resp = (which == 1);
      ev_arb_won  = (which == 2);
      ev_drop     = (which == 3);
      tick();
      ev_sel_done = 0; ev_tgt_resp = 0; ev_arb_won = 0; ev_drop = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 0;
      ev_sel_done = 0; ev_tgt_resp = 0; ev_arb_won = 0; ev_drop = 0;
      gpctl = 8'h00; autodl_busy = 0; gpio_dout = '1; gpio_dir = '1;
      stat_wr_en = 0; stat_wr_data = 0;
      tick(); tick();
      // R1 reset state
      chk("R1 conn", {15'd0, conn}, 16'd0);
      chk("R1 stat_q", {8'd0, stat_q}, 16'd0);
      chk("R1 pads", {6'd0, pad_out, pad_oe}, 16'd0);
      rst_n = 1;
      tick();

      // R2 R3 R4 each set source, R5 clear after each
      for (int s = 0; s < 3; s++) begin
         pulse(s);
         chk(s == 0 ? "R2 set" : (s == 1 ? "R3 set" : "R4 set"), {15'd0, conn}, 16'd1);
         tick();
         chk("R5 hold high", {15'd0, conn}, 16'd1);
         pulse(3);
         chk("R5 clear", {15'd0, conn}, 16'd0);
         tick();
         chk("R5 hold low", {15'd0, conn}, 16'd0);
      end
      // R5 drop wins over simultaneous set
      pulse(0);
      ev_drop = 1; ev_tgt_resp = 1; ev_arb_won = 1; ev_sel_done = 1;
      tick();
      ev_drop = 0; ev_tgt_resp = 0; ev_arb_won = 0; ev_sel_done = 0;
      chk("R5 drop priority", {15'd0, conn}, 16'd0);

      // R6 status mapping and write ignore, from both flag values
      for (int c = 0; c < 2; c++) begin
         if (c == 1) pulse(1);
         chk("R6 map", {8'd0, stat_q}, c ? 16'h0008 : 16'h0000);
         stat_wr_en = 1;
         stat_wr_data = c ? 8'h00 : 8'hFF;
         tick();
         stat_wr_data = 8'h08;
         tick();
         stat_wr_en = 0; stat_wr_data = 0;
         chk("R6 write ignored", {8'd0, stat_q}, c ? 16'h0008 : 16'h0000);
      end
      pulse(3);

      // R7 R8 R9 sweep: qual bits x flag x pin0 data/dir x upper pattern
      for (int q = 0; q < 8; q++) begin
         for (int c = 0; c < 2; c++) begin
            for (int g = 0; g < 4; g++) begin
               logic qual;
               logic [GW-1:0] eo, ee;
               if (c == 1) pulse(0); else pulse(3);
               gpctl       = {1'b0, q[1], q[0], 5'b10101};
               autodl_busy = q[2];
               gpio_dout   = {4'(q + g), g[0]};
               gpio_dir    = {4'(~(q + c)), g[1]};
               tick(); tick();
               qual = q[0] & ~q[1] & ~q[2];
               eo = gpio_dout; ee = gpio_dir;
               if (qual) begin eo[0] = c[0]; ee[0] = 1'b1; end
               chk(qual ? "R7 led pin0" : "R8 gpio pin0",
                   {14'd0, pad_out[0], pad_oe[0]}, {14'd0, eo[0], ee[0]});
               chk("R9 upper pins", {8'd0, pad_out[GW-1:1], pad_oe[GW-1:1]},
                   {8'd0, eo[GW-1:1], ee[GW-1:1]});
            end
         end
      end

      // R10 one-edge latency from flag change and from qualification change
      gpctl = 8'h20; autodl_busy = 0; gpio_dout = '0; gpio_dir = '0;
      pulse(3); tick();
      chk("R10 led low", {15'd0, pad_out[0]}, 16'd0);
      pulse(2);
      chk("R10 flag up, pad still old", {14'd0, conn, pad_out[0]}, 16'b10);
      tick();
      chk("R10 pad after one edge", {15'd0, pad_out[0]}, 16'd1);
      gpctl = 8'h60;
      #1;
      chk("R10 pad before edge", {14'd0, pad_out[0], pad_oe[0]}, 16'b11);
      tick();
      chk("R10 fallback after one edge", {14'd0, pad_out[0], pad_oe[0]}, 16'b00);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule